// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside a processor core and decides which external interrupt the core should service next. Each of `NUM_IRQ` request lines can work as an edge-detected pulse source or as a level source. Every line has an enable bit, a pending bit, an active bit and a priority byte, and software reaches all of them through a word-addressed register port. Only the top `PRIO_BITS` bits of each priority byte are stored.

Among the lines that are both enabled and pending, the block picks the one with the smallest priority value. A programmable split point divides each priority byte into a preempting group field and a subpriority field. The chosen request interrupts the core only when its group value is strictly below the group of the most urgent active handler. When no handler is active, the core runs at an idle level that any group beats. The core accepts an entry with `ack_entry`. On handler exit it raises `exit_valid`, and the controller answers on the next cycle. It either chains straight into a waiting interrupt that outranks the context being resumed, or it tells the core to return.

Register map (word addresses; bank b covers lines 32b..32b+31, bit position = line mod 32): 0x00+b enable set (reads enables), 0x08+b enable clear, 0x10+b pending set (reads pending), 0x18+b pending clear, 0x20+b active (read only), 0x28+b trigger mode (1 = level, 0 = pulse, written directly), 0x40+w priority bytes of lines 4w..4w+3 (byte k in bits 8k+7..8k), 0x80 split field in bits 2..0. Locations with no line behind them read zero and ignore writes.

Top module: `nvx_ctrl`

## Requirements
- R1: After reset all enable, pending, active and mode bits are zero, the split field is zero, and `irq_req`, `exit_chain` and `exit_return` are low.
- R2: Writing ones to an enable-set word sets those enables, and writing ones to an enable-clear word clears them. The enable word reads back the enables. Bits for lines at or above `NUM_IRQ` read zero.
- R3: Writing ones to a pending-set word sets those pending bits, and writing ones to a pending-clear word clears them. The pending word reads back the pending bits. A pending line that is not enabled never raises `irq_req`.
- R4: In pulse mode a 0-to-1 change on a line sets its pending bit on the next clock. A line held high does not set it again after it has been cleared.
- R5: In level mode a high line sets pending on every clock. A software clear therefore has no lasting effect while the line stays high.
- R6: A priority byte keeps only its top `PRIO_BITS` bits, and the lower bits read zero. Priority words beyond the last line read zero and ignore writes.
- R7: `irq_id`/`irq_prio` show the enabled pending line with the smallest priority value. A tie goes to the lower line number.
- R8: With split s, the group of a priority is the byte with bits s..0 cleared. `irq_req` is high exactly when a winner exists and its group is strictly smaller than the smallest group among active lines, or when a winner exists and no line is active. The split field is 3 bits wide.
- R9: `ack_entry` sets the active bit of the line shown on `irq_id` and clears its pending bit, unless a level line is high or a pulse edge arrives in that same cycle.
- R10: `exit_valid` with `exit_id` clears that line's active bit. On the next cycle exactly one of `exit_chain` and `exit_return` pulses. `exit_chain` pulses when the winner's group is strictly smaller than the smallest group among the remaining active lines; with no active line left, any winner chains.
- R11: A priority write changes arbitration from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | External request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| irq_req | output | 1 | Preemption request to the core |
| irq_id | output | IDW | Winning line number |
| irq_prio | output | 8 | Winning line priority byte |
| ack_entry | input | 1 | Core takes the line shown on irq_id |
| exit_valid | input | 1 | Core leaves a handler |
| exit_id | input | IDW | Line whose handler ends |
| exit_chain | output | 1 | Tail-chain into the current winner |
| exit_return | output | 1 | Return to the interrupted context |

## Verification
The bench builds the block with 36 lines and 4 priority bits. The line count puts lines in a second enable bank and a ninth priority word, so the bench can reach bank-boundary reads, bits above the last line and a priority word past the end. Four stored bits leave the lower nibble unimplemented, so the masking of low bits and group splits that fall inside or below the stored field can both be observed. Ties across banks (line 5 against line 33) exercise the lower-number rule.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

  // group value used when no handler is active: larger than any 8-bit group
  localparam logic [8:0] IDLE_GRP = 9'h100;

  // bits of a priority byte that are actually stored
  function automatic logic [7:0] impl_mask(input int pbits);
    return 8'hFF << (8 - pbits);
  endfunction

  // preempting group field of a priority byte for a split point
  function automatic logic [8:0] grp_of(input logic [7:0] prio, input logic [2:0] split);
    logic [7:0] keep;
    keep = 8'hFF << (int'(split) + 1);
    return {1'b0, prio & keep};
  endfunction

endpackage

// File: rtl/nvx_line.sv
module nvx_line #(
  parameter int PRIO_BITS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_in,
  input  logic       en_set,
  input  logic       en_clr,
  input  logic       pd_set,
  input  logic       pd_clr,
  input  logic       mode_we,
  input  logic       mode_wd,
  input  logic       prio_we,
  input  logic [7:0] prio_wd,
  input  logic       ack_hit,
  input  logic       exit_hit,
  output logic       en_q,
  output logic       pend_q,
  output logic       act_q,
  output logic       lvl_q,
  output logic [7:0] prio_q
);

  logic                 in_q;
  logic [PRIO_BITS-1:0] pr_r;
  logic                 hw_set;

  // level: every high cycle; pulse: only the rising edge
  assign hw_set = lvl_q ? irq_in : (irq_in & ~in_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      lvl_q  <= 1'b0;
      pr_r   <= '0;
    end else begin
      in_q <= irq_in;
      if (en_set)      en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
      pend_q <= (pend_q & ~(pd_clr | ack_hit)) | pd_set | hw_set;
      if (ack_hit)       act_q <= 1'b1;
      else if (exit_hit) act_q <= 1'b0;
      if (mode_we) lvl_q <= mode_wd;
      if (prio_we) pr_r <= prio_wd[7 -: PRIO_BITS];
    end
  end

  generate
    if (PRIO_BITS < 8) begin : g_pad
      assign prio_q = {pr_r, {(8 - PRIO_BITS){1'b0}}};
    end else begin : g_full
      assign prio_q = pr_r;
    end
  endgenerate

  assert_pulse_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_q && irq_in && !in_q) |=> pend_q);

  assert_level_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q && irq_in) |=> pend_q);

  assert_entry_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> act_q);

  assert_exit_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_hit && !ack_hit) |=> !act_q);

endmodule

// File: rtl/nvx_arb.sv
module nvx_arb #(
  parameter int N   = 32,
  parameter int IDW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic [N*8-1:0] prio_flat,
  output logic           best_valid,
  output logic [IDW-1:0] best_id,
  output logic [7:0]     best_prio
);

  logic [7:0] p_run;

  // ascending scan with strict compare: equal values keep the lower line
  always_comb begin
    best_valid = 1'b0;
    best_id    = '0;
    p_run      = 8'hFF;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!best_valid || prio_flat[i*8 +: 8] < p_run)) begin
        best_valid = 1'b1;
        best_id    = IDW'(i);
        p_run      = prio_flat[i*8 +: 8];
      end
    end
    best_prio = best_valid ? p_run : 8'h00;
  end

  assert_winner_requests_R7: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> req[best_id]);

endmodule

// File: rtl/nvx_ctx.sv
module nvx_ctx #(
  parameter int N   = 32,
  parameter int IDW = 5
) (
  input  logic [N-1:0]   act_vec,
  input  logic [N*8-1:0] prio_flat,
  input  logic [2:0]     split,
  input  logic           best_valid,
  input  logic [7:0]     best_prio,
  input  logic           exit_valid,
  input  logic [IDW-1:0] exit_id,
  output logic [8:0]     cur_grp,
  output logic [8:0]     ret_grp,
  output logic           preempt,
  output logic           chain_now
);
  import nvx_pkg::*;

  logic [8:0] win_grp;

  always_comb begin
    cur_grp = IDLE_GRP;
    ret_grp = IDLE_GRP;
    for (int i = 0; i < N; i++) begin
      if (act_vec[i] && grp_of(prio_flat[i*8 +: 8], split) < cur_grp)
        cur_grp = grp_of(prio_flat[i*8 +: 8], split);
      if (act_vec[i] && !(exit_valid && exit_id == IDW'(i)) &&
          grp_of(prio_flat[i*8 +: 8], split) < ret_grp)
        ret_grp = grp_of(prio_flat[i*8 +: 8], split);
    end
    win_grp   = grp_of(best_prio, split);
    preempt   = best_valid && (win_grp < cur_grp);
    chain_now = best_valid && (win_grp < ret_grp);
  end

endmodule

// File: rtl/nvx_ctrl.sv
module nvx_ctrl #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 3,
  localparam int IDW      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_req,
  output logic [IDW-1:0]     irq_id,
  output logic [7:0]         irq_prio,
  input  logic               ack_entry,
  input  logic               exit_valid,
  input  logic [IDW-1:0]     exit_id,
  output logic               exit_chain,
  output logic               exit_return
);

  localparam int NBANK = (NUM_IRQ + 31) / 32;
  localparam int NPW   = (NUM_IRQ + 3) / 4;

  logic [NUM_IRQ-1:0]   en_vec, pend_vec, act_vec, lvl_vec;
  logic [NUM_IRQ*8-1:0] prio_flat;
  logic [2:0]           split_q;
  logic                 best_valid;
  logic [IDW-1:0]       best_id;
  logic [7:0]           best_prio;
  logic [8:0]           cur_grp, ret_grp;
  logic                 preempt, chain_now;

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      localparam int BK  = i / 32;
      localparam int BT  = i % 32;
      localparam int PW  = i / 4;
      localparam int PBY = i % 4;
      logic wb;
      assign wb = reg_wr && reg_wdata[BT];
      nvx_line #(.PRIO_BITS(PRIO_BITS)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in[i]),
        .en_set   (wb && reg_addr == 8'(8'h00 + BK)),
        .en_clr   (wb && reg_addr == 8'(8'h08 + BK)),
        .pd_set   (wb && reg_addr == 8'(8'h10 + BK)),
        .pd_clr   (wb && reg_addr == 8'(8'h18 + BK)),
        .mode_we  (reg_wr && reg_addr == 8'(8'h28 + BK)),
        .mode_wd  (reg_wdata[BT]),
        .prio_we  (reg_wr && reg_addr == 8'(8'h40 + PW)),
        .prio_wd  (reg_wdata[PBY*8 +: 8]),
        .ack_hit  (ack_entry && best_valid && best_id == IDW'(i)),
        .exit_hit (exit_valid && exit_id == IDW'(i)),
        .en_q     (en_vec[i]),
        .pend_q   (pend_vec[i]),
        .act_q    (act_vec[i]),
        .lvl_q    (lvl_vec[i]),
        .prio_q   (prio_flat[i*8 +: 8])
      );
    end
  endgenerate

  nvx_arb #(.N(NUM_IRQ), .IDW(IDW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (en_vec & pend_vec),
    .prio_flat  (prio_flat),
    .best_valid (best_valid),
    .best_id    (best_id),
    .best_prio  (best_prio)
  );

  nvx_ctx #(.N(NUM_IRQ), .IDW(IDW)) u_ctx (
    .act_vec    (act_vec),
    .prio_flat  (prio_flat),
    .split      (split_q),
    .best_valid (best_valid),
    .best_prio  (best_prio),
    .exit_valid (exit_valid),
    .exit_id    (exit_id),
    .cur_grp    (cur_grp),
    .ret_grp    (ret_grp),
    .preempt    (preempt),
    .chain_now  (chain_now)
  );

  assign irq_req  = preempt;
  assign irq_id   = best_id;
  assign irq_prio = best_prio;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      split_q     <= 3'd0;
      exit_chain  <= 1'b0;
      exit_return <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 8'h80) split_q <= reg_wdata[2:0];
      exit_chain  <= exit_valid && chain_now;
      exit_return <= exit_valid && !chain_now;
    end
  end

  // read path: zero-padded views so every bank and word slice is in range
  logic [NBANK*32-1:0] en_pad, pend_pad, act_pad, lvl_pad;
  logic [NPW*32-1:0]   prio_pad;
  int                  bsel, wsel;

  assign en_pad   = (NBANK*32)'(en_vec);
  assign pend_pad = (NBANK*32)'(pend_vec);
  assign act_pad  = (NBANK*32)'(act_vec);
  assign lvl_pad  = (NBANK*32)'(lvl_vec);
  assign prio_pad = (NPW*32)'(prio_flat);

  always_comb begin
    reg_rdata = 32'h0;
    bsel      = int'(reg_addr[2:0]);
    wsel      = int'(reg_addr[5:0]);
    case (reg_addr[7:3])
      5'h00, 5'h01: if (bsel < NBANK) reg_rdata = en_pad[bsel*32 +: 32];
      5'h02, 5'h03: if (bsel < NBANK) reg_rdata = pend_pad[bsel*32 +: 32];
      5'h04:        if (bsel < NBANK) reg_rdata = act_pad[bsel*32 +: 32];
      5'h05:        if (bsel < NBANK) reg_rdata = lvl_pad[bsel*32 +: 32];
      5'h08, 5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h0E, 5'h0F:
                    if (wsel < NPW) reg_rdata = prio_pad[wsel*32 +: 32];
      5'h10:        if (bsel == 0) reg_rdata = {29'h0, split_q};
      default:      reg_rdata = 32'h0;
    endcase
  end

  assert_req_enabled_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_vec[irq_id] && pend_vec[irq_id]));

  assert_idle_core_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (best_valid && act_vec == '0) |-> irq_req);

  assert_exit_one_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |=> (exit_chain != exit_return));

  assert_no_answer_without_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !exit_valid |=> !(exit_chain || exit_return));

endmodule

// File: tb/sim_nvx_ctrl.sv
`timescale 1ns/1ps
module sim_nvx_ctrl;

  localparam int N   = 36;
  localparam int PB  = 4;
  localparam int IDW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_addr = 8'h0;
  logic [31:0]   reg_wdata = 32'h0;
  logic [31:0]   reg_rdata;
  logic          irq_req;
  logic [IDW-1:0] irq_id;
  logic [7:0]    irq_prio;
  logic          ack_entry = 1'b0;
  logic          exit_valid = 1'b0;
  logic [IDW-1:0] exit_id = '0;
  logic          exit_chain, exit_return;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  nvx_ctrl #(.NUM_IRQ(N), .PRIO_BITS(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio),
    .ack_entry(ack_entry), .exit_valid(exit_valid), .exit_id(exit_id),
    .exit_chain(exit_chain), .exit_return(exit_return)
  );

  // {write, tag, addr, data-or-expected}
  localparam int NV = 19;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 4'd2,  8'h00, 32'h0000_0005},
    {1'b0, 4'd2,  8'h00, 32'h0000_0005},   // R2 set
    {1'b1, 4'd2,  8'h01, 32'hFFFF_FFFF},
    {1'b0, 4'd2,  8'h01, 32'h0000_000F},   // R2 bits past line 35 read zero
    {1'b1, 4'd2,  8'h08, 32'h0000_0001},
    {1'b0, 4'd2,  8'h00, 32'h0000_0004},   // R2 clear
    {1'b1, 4'd6,  8'h40, 32'hFFFF_FF3F},
    {1'b0, 4'd6,  8'h40, 32'hF0F0_F030},   // R6 low nibble dropped
    {1'b1, 4'd3,  8'h10, 32'h0000_0100},
    {1'b0, 4'd3,  8'h10, 32'h0000_0100},   // R3 set
    {1'b1, 4'd3,  8'h18, 32'h0000_0100},
    {1'b0, 4'd3,  8'h10, 32'h0000_0000},   // R3 clear
    {1'b1, 4'd8,  8'h80, 32'hFFFF_FFFF},
    {1'b0, 4'd8,  8'h80, 32'h0000_0007},   // R8 3-bit split
    {1'b0, 4'd9,  8'h20, 32'h0000_0000},   // R9 nothing active
    {1'b1, 4'd5,  8'h28, 32'h0000_0002},
    {1'b0, 4'd5,  8'h28, 32'h0000_0002},   // R5 mode readback
    {1'b1, 4'd6,  8'h49, 32'h1234_5678},
    {1'b0, 4'd6,  8'h49, 32'h0000_0000}    // R6 word past the end
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    irq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic ack();
    @(negedge clk); ack_entry = 1'b1;
    @(negedge clk); ack_entry = 1'b0;
  endtask

  task automatic leave(input int id);
    @(negedge clk); exit_valid = 1'b1; exit_id = IDW'(id);
    @(negedge clk); exit_valid = 1'b0;
    #1;
  endtask

  task automatic req_chk(input string tag, input logic r, input int id, input logic [7:0] p);
    #1;
    chk({tag, " irq_req"}, 32'(irq_req), 32'(r));
    if (r) begin
      chk({tag, " irq_id"}, 32'(irq_id), 32'(id));
      chk({tag, " irq_prio"}, 32'(irq_prio), 32'(p));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R1 reset state
    rd(8'h00, 32'h0, "R1 enable");
    rd(8'h10, 32'h0, "R1 pending");
    rd(8'h20, 32'h0, "R1 active");
    rd(8'h28, 32'h0, "R1 mode");
    rd(8'h80, 32'h0, "R1 split");
    chk("R1 outputs", {29'h0, irq_req, exit_chain, exit_return}, 32'h0);

    // register vectors
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][44]) wr(VEC[k][39:32], VEC[k][31:0]);
      else begin
        reg_addr = VEC[k][39:32];
        #1;
        checks++;
        if (reg_rdata !== VEC[k][31:0]) begin
          fails++;
          $display("FAIL R%0d vec %0d actual=%h expected=%h", VEC[k][43:40], k, reg_rdata, VEC[k][31:0]);
        end
      end
    end

    // R3 pending but disabled line stays silent
    do_reset();
    wr(8'h10, 32'h0000_0100);
    req_chk("R3 disabled", 1'b0, 0, 8'h0);

    // R7 lowest value wins, tie to lower number across banks
    do_reset();
    wr(8'h40, 32'h4000_0000);   // line3 = 0x40
    wr(8'h41, 32'h0000_2000);   // line5 = 0x20
    wr(8'h48, 32'h0000_2000);   // line33 = 0x20
    wr(8'h00, 32'h0000_0028);
    wr(8'h01, 32'h0000_0002);
    wr(8'h10, 32'h0000_0028);
    wr(8'h11, 32'h0000_0002);
    req_chk("R7 tie", 1'b1, 5, 8'h20);

    // R11 reprioritise takes effect next cycle
    wr(8'h48, 32'h0000_1000);
    req_chk("R11 reprio", 1'b1, 33, 8'h10);

    // R9 entry
    ack();
    rd(8'h21, 32'h0000_0002, "R9 active set");
    rd(8'h11, 32'h0000_0000, "R9 pending cleared");
    // R8 equal-or-lower group does not preempt
    req_chk("R8 no preempt", 1'b0, 0, 8'h0);
    chk("R7 next winner", 32'(irq_id), 32'd5);

    wr(8'h41, 32'h0000_0000);   // line5 -> 0x00, group below 0x10
    req_chk("R8 preempt", 1'b1, 5, 8'h00);
    ack();
    rd(8'h20, 32'h0000_0020, "R9 nested active");
    req_chk("R8 after nest", 1'b0, 0, 8'h0);

    // R10 exit back to line33, line3 (0x40) does not outrank it
    leave(5);
    chk("R10 return", {30'h0, exit_chain, exit_return}, 32'h1);
    rd(8'h20, 32'h0, "R10 active cleared");
    // R10 exit to idle with line3 waiting -> chain
    leave(33);
    chk("R10 chain", {30'h0, exit_chain, exit_return}, 32'h2);
    rd(8'h21, 32'h0, "R10 active cleared 33");
    req_chk("R10 chained winner", 1'b1, 3, 8'h40);

    // R8 split point
    do_reset();
    wr(8'h00, 32'h0000_0006);
    wr(8'h40, 32'h0020_3000);   // line1 = 0x30, line2 = 0x20
    wr(8'h10, 32'h0000_0002);
    req_chk("R8 idle", 1'b1, 1, 8'h30);
    ack();
    wr(8'h80, 32'h5);
    wr(8'h10, 32'h0000_0004);
    req_chk("R8 split5", 1'b0, 0, 8'h0);
    wr(8'h80, 32'h4);
    req_chk("R8 split4", 1'b0, 0, 8'h0);
    wr(8'h80, 32'h3);
    req_chk("R8 split3", 1'b1, 2, 8'h20);

    // R4 pulse mode
    do_reset();
    wr(8'h00, 32'h0000_0080);
    @(negedge clk); irq_in[7] = 1'b1;
    @(negedge clk);
    rd(8'h10, 32'h0000_0080, "R4 edge sets");
    wr(8'h18, 32'h0000_0080);
    rd(8'h10, 32'h0000_0000, "R4 held high no reset");
    @(negedge clk); irq_in[7] = 1'b0;

    // R5 level mode
    wr(8'h28, 32'h0000_0080);
    @(negedge clk); irq_in[7] = 1'b1;
    @(negedge clk);
    wr(8'h18, 32'h0000_0080);
    rd(8'h10, 32'h0000_0080, "R5 clear ignored");
    @(negedge clk); irq_in[7] = 1'b0;
    @(negedge clk);
    wr(8'h18, 32'h0000_0080);
    rd(8'h10, 32'h0000_0000, "R5 clear after low");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule